// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block is a master for a three-wire serial EEPROM: select, serial clock and data toward the memory, plus one data line back. A single pulse on `start` has it fetch three 16-bit words from EEPROM locations 0, 1 and 2. Each word is its own framed read transaction. The block then joins the words into a 48-bit station address and announces the result with a one-cycle `done` pulse.

Bit timing is built from a phase counter. Every low half and every high half of the serial clock lasts `PHASE_CYCLES` system clocks. The data line coming back from the memory passes through a two-flop synchronizer before it is sampled.

Each frame contains the following, in order:
- one setup phase with only the select raised;
- a leading zero bit;
- the read opcode;
- an 8-bit address;
- seventeen receive pulses, of which the first bit is thrown away.

Top module: `mw_station_addr_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `station_addr` are all 0.
- R2: `start` is accepted only when the block is idle and `done` is low. `busy` rises in the cycle after an accepted start. A `start` raised while `busy` is high, or in the cycle in which `done` is high, launches no frame and causes no extra `done`.
- R3: Each frame begins with `ee_cs` rising while `ee_sk` and `ee_di` are 0. The first rising edge of `ee_sk` in the frame comes exactly 2*PHASE_CYCLES clocks after the rise of `ee_cs`.
- R4: Each frame places 12 bits on `ee_di` before the receive part, each bit sampled at a rising `ee_sk`. The bits are, in order: 0, 1, 1, 0, and then the 8-bit word address, most significant bit first. `ee_di` does not change while `ee_sk` stays high.
- R5: Each high half of `ee_sk` lasts exactly PHASE_CYCLES clocks. Every low half between two pulses of one frame also lasts exactly PHASE_CYCLES clocks.
- R6: After the command, the frame has 17 more `ee_sk` pulses, 29 pulses in total. `ee_do` is sampled at the end of each low half, after two synchronizer stages. The first received bit is dropped, and the next 16 form the word, most significant bit first.
- R7: Three frames are issued per start, addressing words 0, 1 and 2 in that order. `ee_cs`, `ee_sk` and `ee_di` stay low for at least PHASE_CYCLES clocks between frames.
- R8: `station_addr[15:0]` holds word 0, `[31:16]` holds word 1 and `[47:32]` holds word 2. Byte k of the address is bits 8k+7..8k, so each word contributes its low byte before its high byte.
- R9: `done` is high for exactly one cycle, with `busy` low in that cycle. `station_addr` carries the new value from that cycle on and changes at no other time outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin loading the address |
| ee_do | input | 1 | Serial data returned by the EEPROM (asynchronous) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data driven to the EEPROM |
| busy | output | 1 | High from an accepted start until completion |
| done | output | 1 | One-cycle pulse: station_addr is valid |
| station_addr | output | 48 | Assembled 48-bit station address |

## Verification
Two events can land in the same clock: the `done` pulse that closes a load, and a fresh `start` from the host. At the moment `done` is high the sequencer is already idle. Without a guard, that request would open a new load straight away. The bench watches for `done` and raises `start` so that the pulse covers the clock edge at which `done` is still high. It then expects `busy`, `ee_cs` and the responder's frame count to stay quiet for several phases, and it expects no further `done` to appear against the empty scoreboard queue.

// File: rtl/mwl_pkg.sv
`timescale 1ns/1ps
package mwl_pkg;

  // read opcode, sent after the leading zero bit
  localparam logic [2:0] OPC_READ = 3'b110;

  typedef enum logic [2:0] {
    F_IDLE,
    F_SETUP,
    F_TXL,
    F_TXH,
    F_RXL,
    F_RXH,
    F_GAP
  } frame_st_t;

  typedef enum logic [1:0] {
    T_IDLE,
    T_LAUNCH,
    T_WAIT,
    T_FIN
  } seq_st_t;

endpackage

// File: rtl/mw_sync2.sv
`timescale 1ns/1ps
module mw_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d_async;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mw_phase_timer.sv
`timescale 1ns/1ps
module mw_phase_timer #(
  parameter int PHASE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (PHASE_CYCLES > 2) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_frame_fsm.sv
`timescale 1ns/1ps
module mw_frame_fsm
  import mwl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              do_s,
  output logic              ready,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int CMD_W   = ADDR_W + 4;          // zero bit + opcode + address
  localparam int RX_BITS = WORD_W + 1;          // dummy bit + data
  localparam int MAXB    = (CMD_W > RX_BITS) ? CMD_W : RX_BITS;
  localparam int BC_W    = $clog2(MAXB) + 1;
  localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_W - 1);
  localparam logic [BC_W-1:0] RX_LAST  = BC_W'(RX_BITS - 1);

  frame_st_t         st;
  logic [CMD_W-1:0]  shreg;
  logic [WORD_W-1:0] rx;
  logic [BC_W-1:0]   cnt;

  assign ready = (st == F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= F_IDLE;
      cs         <= 1'b0;
      sk         <= 1'b0;
      di         <= 1'b0;
      shreg      <= '0;
      rx         <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          st    <= F_SETUP;
          cs    <= 1'b1;
          sk    <= 1'b0;
          di    <= 1'b0;
          shreg <= {1'b0, OPC_READ, addr};
          cnt   <= '0;
        end
        F_SETUP: if (tick) begin
          st <= F_TXL;
          di <= shreg[CMD_W-1];
        end
        F_TXL: if (tick) begin
          st <= F_TXH;
          sk <= 1'b1;
        end
        F_TXH: if (tick) begin
          sk    <= 1'b0;
          shreg <= shreg << 1;
          if (cnt == CMD_LAST) begin
            st  <= F_RXL;
            di  <= 1'b0;
            cnt <= '0;
          end else begin
            st  <= F_TXL;
            di  <= shreg[CMD_W-2];
            cnt <= cnt + 1'b1;
          end
        end
        F_RXL: if (tick) begin
          st <= F_RXH;
          sk <= 1'b1;
          rx <= {rx[WORD_W-2:0], do_s};
        end
        F_RXH: if (tick) begin
          sk <= 1'b0;
          if (cnt == RX_LAST) begin
            st         <= F_GAP;
            cs         <= 1'b0;
            di         <= 1'b0;
            word       <= rx;
            word_valid <= 1'b1;
          end else begin
            st  <= F_RXL;
            cnt <= cnt + 1'b1;
          end
        end
        F_GAP: if (tick) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  // serial clock only toggles inside a selected frame
  assert_sk_inside_cs_R3: assert property (@(posedge clk) disable iff (rst)
    sk |-> cs);

  // data toward the memory holds while the clock is high
  assert_di_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(di));

  // receive part drives no data
  assert_di_quiet_rx_R6: assert property (@(posedge clk) disable iff (rst)
    (st == F_RXL || st == F_RXH) |-> !di);

endmodule

// File: rtl/mw_station_addr_loader.sv
`timescale 1ns/1ps
module mw_station_addr_loader
  import mwl_pkg::*;
#(
  parameter int PHASE_CYCLES = 4,
  parameter int ADDR_W       = 8,
  parameter int WORD_W       = 16,
  parameter int NUM_WORDS    = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        ee_do,
  output logic                        ee_cs,
  output logic                        ee_sk,
  output logic                        ee_di,
  output logic                        busy,
  output logic                        done,
  output logic [WORD_W*NUM_WORDS-1:0] station_addr
);
  localparam int OUT_W = WORD_W * NUM_WORDS;
  localparam int WI_W  = $clog2(NUM_WORDS);
  localparam logic [WI_W-1:0] WI_LAST = WI_W'(NUM_WORDS - 1);
  localparam int SR_W  = $clog2(PHASE_CYCLES + 1) + 1;

  seq_st_t           tst;
  logic [WI_W-1:0]   widx;
  logic [OUT_W-1:0]  acc;
  logic              do_s;
  logic              tick;
  logic              f_ready;
  logic              go;
  logic              word_valid;
  logic [WORD_W-1:0] word;

  mw_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (ee_do),
    .q       (do_s)
  );

  mw_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (!f_ready),
    .tick (tick)
  );

  assign go = (tst == T_LAUNCH) && f_ready;

  mw_frame_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .addr       (ADDR_W'(widx)),
    .tick       (tick),
    .do_s       (do_s),
    .ready      (f_ready),
    .cs         (ee_cs),
    .sk         (ee_sk),
    .di         (ee_di),
    .word_valid (word_valid),
    .word       (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tst          <= T_IDLE;
      busy         <= 1'b0;
      done         <= 1'b0;
      widx         <= '0;
      acc          <= '0;
      station_addr <= '0;
    end else begin
      done <= 1'b0;
      case (tst)
        T_IDLE: if (start && !done) begin
          tst  <= T_LAUNCH;
          busy <= 1'b1;
          widx <= '0;
        end
        T_LAUNCH: if (f_ready) tst <= T_WAIT;
        T_WAIT: if (word_valid) begin
          acc[widx*WORD_W +: WORD_W] <= word;
          if (widx == WI_LAST) begin
            tst <= T_FIN;
          end else begin
            widx <= widx + 1'b1;
            tst  <= T_LAUNCH;
          end
        end
        T_FIN: if (f_ready) begin
          station_addr <= acc;
          done         <= 1'b1;
          busy         <= 1'b0;
          tst          <= T_IDLE;
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

  // length of the current high half of the serial clock
  logic [SR_W-1:0] sk_run;
  always_ff @(posedge clk) begin
    if (rst || !ee_sk) sk_run <= '0;
    else               sk_run <= sk_run + 1'b1;
  end

  assert_sk_high_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_sk) |-> (sk_run == SR_W'(PHASE_CYCLES)));

  assert_frame_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(station_addr));

endmodule

// File: tb/mw_station_addr_loader_tb_top.sv
`timescale 1ns/1ps
module mw_station_addr_loader_tb_top;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ee_do = 1'b0;
  logic        ee_cs, ee_sk, ee_di, busy, done;
  logic [47:0] station_addr;

  always #2.5 clk = ~clk;

  mw_station_addr_loader #(.PHASE_CYCLES(PH)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .ee_do        (ee_do),
    .ee_cs        (ee_cs),
    .ee_sk        (ee_sk),
    .ee_di        (ee_di),
    .busy         (busy),
    .done         (done),
    .station_addr (station_addr)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM responder + frame monitor -------------
  logic [15:0] eep [0:255];
  logic [15:0] cur_word;
  logic [11:0] cmd_cap;
  logic        sk_q = 1'b0, cs_q = 1'b0;
  int          rise_cnt = 0;
  int          cyc = 0;
  int          cs_rise_cyc = 0, last_fall_cyc = 0;
  int          hi_run = 0, lo_run = 0, width_bad = 0;
  int          frame_in_run = 0, frames_total = 0;
  bit          aborting = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (ee_cs && !cs_q) begin
      cs_rise_cyc = cyc;
      rise_cnt    = 0;
      width_bad   = 0;
      lo_run      = 0;
      hi_run      = 0;
      check(!ee_sk && !ee_di, "R3", "sk/di at select rise", {ee_sk, ee_di}, 0);
      if (frames_total > 0)
        check(cyc - last_fall_cyc >= PH, "R7", "deselect gap", cyc - last_fall_cyc, PH);
    end
    if (ee_cs && ee_sk && !sk_q) begin
      if (rise_cnt == 0)
        check(cyc - cs_rise_cyc == 2*PH, "R3", "select to first clock", cyc - cs_rise_cyc, 2*PH);
      else if (lo_run != PH)
        width_bad++;
      if (rise_cnt < 12) cmd_cap = {cmd_cap[10:0], ee_di};
      if (rise_cnt == 11) begin
        cur_word = eep[cmd_cap[7:0]];
        ee_do   <= 1'b0;                       // dummy bit
      end else if (rise_cnt >= 12 && rise_cnt < 28) begin
        ee_do   <= cur_word[27 - rise_cnt];
      end else if (rise_cnt >= 28) begin
        ee_do   <= 1'b0;
      end
      rise_cnt++;
      hi_run = 0;
    end
    if (ee_cs && !ee_sk && sk_q) begin
      if (hi_run != PH) width_bad++;
      lo_run = 0;
    end
    if (ee_sk) hi_run++;
    else       lo_run++;
    if (!ee_cs && cs_q) begin
      if (!aborting) begin
        check(rise_cnt == 29, "R6", "clock pulses per frame", rise_cnt, 29);
        check(cmd_cap == {1'b0, 3'b110, 8'(frame_in_run)}, "R4", "command bits (R7 address order)",
              cmd_cap, {1'b0, 3'b110, 8'(frame_in_run)});
        check(width_bad == 0, "R5", "phase width errors", width_bad, 0);
      end
      frame_in_run++;
      frames_total++;
      last_fall_cyc = cyc;
    end
    sk_q = ee_sk;
    cs_q = ee_cs;
  end

  // ---------------- scoreboard monitor ---------------------------------------
  logic [47:0] exp_q [$];
  logic        done_q = 1'b0;

  always @(negedge clk) begin
    if (done) begin
      check(!busy, "R9", "busy during done", busy, 0);
      check(!done_q, "R9", "done width", done_q, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected done", 1, 0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check(station_addr == e, "R8", "station address", station_addr, e);
      end
    end
    done_q = done;
  end

  // ---------------- driver ---------------------------------------------------
  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_words(input logic [15:0] w0, w1, w2, input bit poke_busy,
                           input bit collide);
    eep[0] = w0; eep[1] = w1; eep[2] = w2;
    exp_q.push_back({w2, w1, w0});
    frame_in_run = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R2", "busy after start", busy, 1);
    if (poke_busy) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_done();
    if (collide) begin
      int ft;
      ft = frames_total;
      start = 1'b1;                       // covers the edge where done is high
      @(negedge clk); start = 1'b0;
      repeat (6*PH) @(negedge clk);
      check(!busy && !ee_cs && frames_total == ft, "R2", "start during done ignored",
            {busy, ee_cs}, 0);
    end else begin
      @(negedge clk);
    end
    check(station_addr == {w2, w1, w0}, "R9", "address held after done",
          station_addr, {w2, w1, w0});
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) eep[i] = 16'hC3C3 ^ 16'(i);
    cmd_cap  = '0;
    cur_word = '0;
    repeat (4) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 0 && station_addr == 0, "R1",
          "outputs in reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 0 && station_addr == 0, "R1",
          "outputs after reset", station_addr, 0);

    run_words(16'h0201, 16'h0403, 16'h0605, 1'b0, 1'b0);  // byte order R8
    run_words(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    run_words(16'h8001, 16'hAAAA, 16'h5555, 1'b0, 1'b0);  // R6 msb/lsb edges
    run_words(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    run_words(16'h1234, 16'h5678, 16'h9ABC, 1'b1, 1'b0);  // start while busy R2
    run_words(16'hDEAD, 16'hBEEF, 16'hCAFE, 1'b0, 1'b1);  // start on done R2

    // reset in the middle of a load clears everything (R1)
    eep[0] = 16'h1111; eep[1] = 16'h2222; eep[2] = 16'h3333;
    frame_in_run = 0;
    aborting = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done} == 0 && station_addr == 0, "R1",
          "mid-load reset", station_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    aborting = 1'b0;
    run_words(16'h0A0B, 16'h0C0D, 16'h0E0F, 1'b0, 1'b0);

    check(exp_q.size() == 0, "R9", "pending expected results", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule